// File: doc/BRIEF.md
# Count-Through RAM Self-Test Engine

This engine checks a small single-port RAM one byte location at a time. It visits each location in ascending address order. For each one it first writes zero, then writes every larger value in turn, and finally writes zero again once the count wraps. After every write it reads the location back and compares the result with the value it wrote. It then moves on to the next location. Every tested location therefore ends the sweep holding zero.

A one-cycle `start` pulse captures the address window given by `range_lo` and `range_hi`. The two highest addresses of that window are kept for return context and are never accessed. The tested locations are `range_lo` up to `range_hi - 2`.

When the sweep ends, `done` pulses and `pass` reports whether every readback matched. On the first mismatch the engine records the failing address. It then either finishes the whole sweep or, when `abort_on_err` is high, stops at once.

States, with the transitions between them:
- `ST_IDLE` waits for start. From there, start with an empty window goes to `ST_FINISH`, and any other start goes to `ST_WRITE`.
- `ST_WRITE` drives one write and always goes to `ST_READ`.
- `ST_READ` issues the readback and always goes to `ST_CHECK`.
- `ST_CHECK` compares the returned data. It then does one of four things:
  - "abort": on a mismatch with `abort_on_err` high, it goes to `ST_FINISH`.
  - "step": if the cell has not wrapped yet, it goes to `ST_WRITE` with the value plus one.
  - "advance": if the cell has wrapped and is not the last one, it goes to `ST_WRITE` at the next address with value 0.
  - "last": if the last cell has wrapped, it goes to `ST_FINISH`.
- `ST_FINISH` pulses done and always goes to `ST_IDLE`.

Top module: `cell_count_test`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done`, `pass`, `ram_we` and `ram_re` are all 0.
- R2: Each tested location receives exactly 2^DATA_W + 1 writes (257 with 8-bit data), with the values 0, 1, ..., 255, 0 in that order. Locations are completed in ascending address order.
- R3: Every write is followed in the next cycle by a read of the same address. A write and a read never occur in the same cycle.
- R4: Only addresses from `range_lo` to `range_hi - 2` are written or read. If `range_hi < range_lo + 2`, nothing is accessed and the run ends with `pass` = 1.
- R5: Once `done` has pulsed, `pass` is 1 if and only if every readback matched. When `pass` is 0, `fail_addr` holds the lowest address (the first in sweep order) whose readback mismatched. `pass` does not change while the engine is idle.
- R6: With `abort_on_err` high, the engine makes no further access after the first mismatch. `done` appears 3·(k+1) cycles after that cell's first write, where k is the index of the failing step (step k wrote the value k mod 256).
- R7: `busy` is high from the cycle after an accepted start until the cycle after `done`. `done` is high for exactly one cycle. A start that arrives while `busy` is high is ignored, and so is the window presented with it. No RAM access happens while `busy` is low.
- R8: With no aborted mismatch, `done` is observed N·3·(2^DATA_W + 1) + 1 falling-edge samples after the start edge, where N is the number of tested locations.
- R9: At the end of a run that was not aborted, every tested location holds 0. Untested locations keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| abort_on_err | input | 1 | Stop at the first mismatch when high |
| range_lo | input | ADDR_W | First address of the window |
| range_hi | input | ADDR_W | Last address of the window (this and the one below are reserved) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| pass | output | 1 | High when the last sweep saw no mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable; data returns one cycle later |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data |

## Verification
The hardest situation to reach is an abort partway through a cell's count. A stuck-at-zero bit only shows up once the counted value first sets that bit, so the mismatch and the stop land hundreds of cycles into the cell. The bench's RAM model applies per-address OR and clear masks on readback. The bench places such faults at chosen and at random addresses, including on the reserved top pair where they must stay unseen. From each mask it computes the first failing step, and from that the exact cycle at which `done` must appear. A second start pulse with a wider window is also injected mid-sweep to show that it changes neither the accessed addresses nor the timing.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_FINISH
    } cct_state_e;

    // Cycles spent on one write/readback/compare step.
    localparam int STEP_CYCLES = 3;

endpackage

// File: rtl/cct_cursor.sv
module cct_cursor #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              advance,
    input  logic [ADDR_W-1:0] range_lo,
    input  logic [ADDR_W-1:0] range_hi,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] value,
    output logic              wrapped,
    output logic              last_cell,
    output logic              range_empty
);

    localparam int                SPAN_W   = ADDR_W + 1;
    localparam logic [SPAN_W-1:0] RESERVED = SPAN_W'(2);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] last_q;
    logic [DATA_W-1:0] val_q;
    logic              first_q;

    // Window too small once the reserved top pair is removed.
    assign range_empty = {1'b0, range_hi} < ({1'b0, range_lo} + RESERVED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            last_q  <= '0;
            val_q   <= '0;
            first_q <= 1'b1;
        end else if (load) begin
            addr_q  <= range_lo;
            last_q  <= range_hi - ADDR_W'(2);
            val_q   <= '0;
            first_q <= 1'b1;
        end else if (advance) begin
            addr_q  <= addr_q + ADDR_W'(1);
            val_q   <= '0;
            first_q <= 1'b1;
        end else if (step) begin
            val_q   <= val_q + DATA_W'(1);
            first_q <= 1'b0;
        end
    end

    assign addr      = addr_q;
    assign value     = val_q;
    // A zero that is not the opening write means the count has wrapped.
    assign wrapped   = (val_q == '0) && !first_q;
    assign last_cell = (addr_q == last_q);

endmodule

// File: rtl/cct_verdict.sv
module cct_verdict #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              check_en,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    input  logic [ADDR_W-1:0] addr,
    output logic              mismatch,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr
);

    logic              pass_q;
    logic              seen_q;
    logic [ADDR_W-1:0] fail_q;

    assign mismatch = check_en && (rdata != expected);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            seen_q <= 1'b0;
            fail_q <= '0;
        end else if (clear) begin
            pass_q <= 1'b1;
            seen_q <= 1'b0;
            fail_q <= '0;
        end else if (mismatch && !seen_q) begin
            pass_q <= 1'b0;
            seen_q <= 1'b1;
            fail_q <= addr;
        end
    end

    assign pass      = pass_q;
    assign fail_addr = fail_q;

endmodule

// File: rtl/cct_fsm.sv
module cct_fsm
    import cct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort_on_err,
    input  logic range_empty,
    input  logic wrapped,
    input  logic last_cell,
    input  logic mismatch,
    output logic load,
    output logic check_en,
    output logic step,
    output logic advance,
    output logic ram_we,
    output logic ram_re,
    output logic busy,
    output logic done
);

    cct_state_e state_q;
    cct_state_e state_d;
    logic       halt;

    assign halt = mismatch && abort_on_err;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = range_empty ? ST_FINISH : ST_WRITE;
            end
            ST_WRITE:  state_d = ST_READ;
            ST_READ:   state_d = ST_CHECK;
            ST_CHECK: begin
                if (halt)                       state_d = ST_FINISH;
                else if (wrapped && last_cell)  state_d = ST_FINISH;
                else                            state_d = ST_WRITE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load     = 1'b0;
        check_en = 1'b0;
        step     = 1'b0;
        advance  = 1'b0;
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_WRITE: ram_we = 1'b1;
            ST_READ:  ram_re = 1'b1;
            ST_CHECK: begin
                check_en = 1'b1;
                step     = !halt && !wrapped;
                advance  = !halt && wrapped && !last_cell;
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/cell_count_test.sv
module cell_count_test #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort_on_err,
    input  logic [ADDR_W-1:0] range_lo,
    input  logic [ADDR_W-1:0] range_hi,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);

    logic              load;
    logic              check_en;
    logic              step;
    logic              advance;
    logic              wrapped;
    logic              last_cell;
    logic              range_empty;
    logic              mismatch;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_val;

    cct_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .abort_on_err (abort_on_err),
        .range_empty  (range_empty),
        .wrapped      (wrapped),
        .last_cell    (last_cell),
        .mismatch     (mismatch),
        .load         (load),
        .check_en     (check_en),
        .step         (step),
        .advance      (advance),
        .ram_we       (ram_we),
        .ram_re       (ram_re),
        .busy         (busy),
        .done         (done)
    );

    cct_cursor #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .advance     (advance),
        .range_lo    (range_lo),
        .range_hi    (range_hi),
        .addr        (cur_addr),
        .value       (cur_val),
        .wrapped     (wrapped),
        .last_cell   (last_cell),
        .range_empty (range_empty)
    );

    cct_verdict #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load),
        .check_en  (check_en),
        .rdata     (ram_rdata),
        .expected  (cur_val),
        .addr      (cur_addr),
        .mismatch  (mismatch),
        .pass      (pass),
        .fail_addr (fail_addr)
    );

    assign ram_addr  = cur_addr;
    assign ram_wdata = cur_val;

endmodule

// File: rtl/cell_count_test_chk.sv
module cell_count_test_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] range_lo,
    input logic [ADDR_W-1:0] range_hi,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_re,
    input logic              busy,
    input logic              done,
    input logic              pass
);

    localparam logic [ADDR_W:0] TOP_GAP = (ADDR_W + 1)'(2);

    logic [ADDR_W-1:0] win_lo_q;
    logic [ADDR_W-1:0] win_hi_q;
    logic              in_window;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_lo_q <= '0;
            win_hi_q <= '0;
        end else if (start && !busy) begin
            win_lo_q <= range_lo;
            win_hi_q <= range_hi;
        end
    end

    assign in_window = (ram_addr >= win_lo_q) &&
                       (({1'b0, ram_addr} + TOP_GAP) <= {1'b0, win_hi_q});

    // R3
    rd_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (ram_re && ram_addr == $past(ram_addr)));

    // R3
    wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R4
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> in_window);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_we && !ram_re && !done));

    // R5
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pass));

endmodule

bind cell_count_test cell_count_test_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .range_lo (range_lo),
    .range_hi (range_hi),
    .ram_addr (ram_addr),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .busy     (busy),
    .done     (done),
    .pass     (pass)
);

// File: tb/cell_count_test_tb.sv
module cell_count_test_tb;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int STEPS    = (1 << DATA_W) + 1;
    localparam int CELL_CYC = 3 * STEPS;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              start;
    logic              abort_on_err;
    logic [ADDR_W-1:0] range_lo;
    logic [ADDR_W-1:0] range_hi;
    logic              busy;
    logic              done;
    logic              pass;
    logic [ADDR_W-1:0] fail_addr;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic              ram_re;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] rdata_q;

    cell_count_test u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .abort_on_err (abort_on_err),
        .range_lo     (range_lo),
        .range_hi     (range_hi),
        .busy         (busy),
        .done         (done),
        .pass         (pass),
        .fail_addr    (fail_addr),
        .ram_addr     (ram_addr),
        .ram_we       (ram_we),
        .ram_re       (ram_re),
        .ram_wdata    (ram_wdata),
        .ram_rdata    (rdata_q)
    );

    // RAM model with read faults, plus access monitor
    logic [DATA_W-1:0] mem  [DEPTH];
    logic [DATA_W-1:0] pre  [DEPTH];
    logic [DATA_W-1:0] orm  [DEPTH];
    logic [DATA_W-1:0] clrm [DEPTH];
    int                wcount [DEPTH];
    int                e2, e3, e4, last_wa;
    int                lo_c, hi_c;
    logic              pv_en;
    logic [ADDR_W-1:0] pv_addr;
    logic [DATA_W-1:0] pv_data;

    int n_chk = 0;
    int n_err = 0;

    always @(posedge clk) begin
        if (pv_en) begin
            mem[pv_addr]    <= pv_data;
            wcount[pv_addr] <= 0;
            if (pv_addr == '0) begin
                e2 <= 0; e3 <= 0; e4 <= 0; last_wa <= -1;
            end
        end else begin
            if (ram_we) begin
                if (int'(ram_addr) < lo_c || int'(ram_addr) > hi_c - 2) e4 <= e4 + 1;
                if (int'(ram_addr) < last_wa || wcount[ram_addr] > 256 ||
                    ram_wdata != DATA_W'(wcount[ram_addr] % 256)) e2 <= e2 + 1;
                wcount[ram_addr] <= wcount[ram_addr] + 1;
                last_wa          <= int'(ram_addr);
                mem[ram_addr]    <= ram_wdata;
            end
            if (ram_re) begin
                if (int'(ram_addr) != last_wa) e3 <= e3 + 1;
                if (int'(ram_addr) < lo_c || int'(ram_addr) > hi_c - 2) e4 <= e4 + 1;
                rdata_q <= (mem[ram_addr] | orm[ram_addr]) & ~clrm[ram_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_bad(input logic [DATA_W-1:0] o, input logic [DATA_W-1:0] c);
        for (int k = 0; k < STEPS; k++) begin
            logic [DATA_W-1:0] v;
            v = DATA_W'(k);
            if (((v | o) & ~c) != v) return k;
        end
        return -1;
    endfunction

    task automatic clear_faults();
        for (int i = 0; i < DEPTH; i++) begin
            orm[i] = '0; clrm[i] = '0;
        end
    endtask

    task automatic preset();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            pv_en   = 1'b1;
            pv_addr = ADDR_W'(i);
            pv_data = DATA_W'($urandom);
            pre[i]  = pv_data;
        end
        @(negedge clk);
        pv_en = 1'b0;
    endtask

    task automatic run_case(input int lo, input int hi, input bit abrt, input bit poke);
        int n, f, s, expl, cyc, badw, badm;
        lo_c = lo; hi_c = hi;
        preset();
        n = (hi - lo >= 2) ? hi - lo - 1 : 0;
        f = -1; s = -1;
        for (int a = lo; a < lo + n; a++) begin
            int k;
            k = first_bad(orm[a], clrm[a]);
            if (k >= 0 && f < 0) begin f = a; s = k; end
        end
        expl = (abrt && f >= 0) ? (f - lo) * CELL_CYC + 3 * (s + 1) : n * CELL_CYC;
        range_lo = ADDR_W'(lo); range_hi = ADDR_W'(hi);
        abort_on_err = abrt; start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = poke && (cyc == 5);
            if (start) begin range_lo = '0; range_hi = ADDR_W'(DEPTH - 1); end
            if (cyc == 1) chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        end while (!done && cyc <= expl + 20);
        start = 1'b0;
        chk(done == 1'b1, "R7 done seen", int'(done), 1);
        if (abrt && f >= 0) chk(cyc == expl + 1, "R6 abort timing", cyc, expl + 1);
        else                chk(cyc == expl + 1, "R8 sweep latency", cyc, expl + 1);
        chk(pass == (f < 0), "R5 pass flag", int'(pass), int'(f < 0));
        if (f >= 0) chk(int'(fail_addr) == f, "R5 fail address", int'(fail_addr), f);
        @(negedge clk);
        chk(!done && !busy, "R7 done one cycle", int'(done) + 2 * int'(busy), 0);
        chk(e2 == 0, "R2 write order/values", e2, 0);
        chk(e3 == 0, "R3 read after write", e3, 0);
        chk(e4 == 0, "R4 access window", e4, 0);
        badw = 0; badm = 0;
        for (int a = 0; a < DEPTH; a++) begin
            int ew;
            logic [DATA_W-1:0] em;
            if (a < lo || a >= lo + n)        ew = 0;
            else if (!abrt || f < 0 || a < f) ew = STEPS;
            else if (a == f)                  ew = s + 1;
            else                              ew = 0;
            if (ew == 0)          em = pre[a];
            else if (ew == STEPS) em = '0;
            else                  em = DATA_W'(s);
            if (wcount[a] != ew) badw++;
            if (mem[a] != em)    badm++;
        end
        chk(badw == 0, "R2 per-cell write count", badw, 0);
        chk(badm == 0, "R9 final contents", badm, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R8 watchdog: actual=190000 expected<190000 cycles");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        rst_n = 1'b0; start = 1'b0; abort_on_err = 1'b0;
        range_lo = '0; range_hi = '0; pv_en = 1'b0; pv_addr = '0; pv_data = '0;
        lo_c = 0; hi_c = 0;
        clear_faults();
        repeat (3) @(negedge clk);
        chk({busy, done, pass, ram_we, ram_re} == 5'b0, "R1 in reset",
            int'({busy, done, pass, ram_we, ram_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, pass, ram_we, ram_re} == 5'b0, "R1 after reset",
            int'({busy, done, pass, ram_we, ram_re}), 0);

        // Top of the space: 126 and 127 stay untouched (R4)
        run_case(100, 127, 1'b0, 1'b0);
        // Empty windows (R4)
        run_case(10, 11, 1'b0, 1'b0);
        run_case(20, 20, 1'b1, 1'b0);
        // Single cell
        run_case(5, 7, 1'b0, 1'b0);
        // Fault on a reserved address is never seen (R4)
        orm[42] = 8'h01;
        run_case(30, 43, 1'b0, 1'b0);
        clear_faults();
        // Two faults, full sweep: lowest address reported (R5)
        clrm[33] = 8'h10; orm[35] = 8'h80;
        run_case(30, 40, 1'b0, 1'b0);
        // Same faults with abort: stops at value 16 of cell 33 (R6)
        run_case(30, 40, 1'b1, 1'b0);
        clear_faults();
        // Start while busy is ignored (R7)
        run_case(60, 66, 1'b0, 1'b1);

        for (int r = 0; r < 8; r++) begin
            int lo, hi, fa;
            lo = $urandom_range(110, 0);
            hi = lo + $urandom_range(12, 2);
            clear_faults();
            if ($urandom_range(1, 0) == 1) begin
                fa = $urandom_range(hi, lo);
                if ($urandom_range(1, 0) == 1) orm[fa]  = DATA_W'($urandom_range(255, 1));
                else                           clrm[fa] = DATA_W'($urandom_range(255, 1));
            end
            run_case(lo, hi, 1'($urandom_range(1, 0)), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule